// File: doc/BRIEF.md
# Byte-Lane Bus Access Guard

This block sits in front of the register space of a 32-bit I/O port. It holds a protection word with one attribute byte per data byte lane. For each bus request it works out the requester's class from its security state and privilege level. It then checks that class and the access direction against the attribute of every byte lane the request enables. A permitted request goes straight through to the port registers. A denied request never reaches them and gets an error response.

The protection word is mapped at one word address (`ATTR_ADDR`) of the guarded space. Only a privileged secure requester may write it. Any requester may read it, so software can inspect the current policy. Every other address is forwarded to the target port. Responses come back exactly one clock after the request, with the error flag and, for reads, the returned data.

Top module: `acc_byte_guard`

## Requirements
- R1: After reset the protection word is zero, so every lane allows every class. `rsp_valid`, `rsp_err` and `tgt_valid` are low until a request arrives.
- R2: Requester classes are user nonsecure (UNS), user secure (US) and privileged secure (PS). The 3-bit lane code gives each class these rights:

  | Code | UNS | US | PS |
  |------|-----|----|----|
  | 0 | read and write | read and write | read and write |
  | 1 | read only | read and write | read and write |
  | 2 | none | read and write | read and write |
  | 3 | read only | read only | read and write |
  | 4 | none | read only | read and write |
  | 5 | none | none | read and write |
  | 6 | none | none | read only |
  | 7 | none | none | none |
- R3: The attribute byte of lane i is bits [8i+7:8i] of the protection word, with lane 0 in the lowest byte. The lane code is bits [8i+2:8i]. Lane i guards `req_be[i]` and data bits [8i+7:8i].
- R4: When bit 8i+7 (the bypass bit) of lane i's attribute is set, every access to that lane is allowed, whatever its code.
- R5: A request is granted only when every lane enabled in `req_be` permits it. Lanes that are not enabled do not affect the decision.
- R6: A denied request to the target address space raises no `tgt_valid`, so no lane is written. `rsp_err` is high for exactly the one response cycle.
- R7: A denied read returns all-zero `rsp_rdata`.
- R8: A nonsecure requester with `req_priv` high is checked as user nonsecure.
- R9: A write to `ATTR_ADDR` takes effect only for a privileged secure requester, and only in the byte lanes it enables. A write from any other class is answered with an error and leaves the word unchanged.
- R10: Every cycle with `req_valid` high produces `rsp_valid` high in the next cycle, and only then. A granted read returns the target data that was present in the request cycle.
- R11: Reads of `ATTR_ADDR` are granted to every class and return the protection word, whatever the lane attributes are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address in the guarded space |
| req_be | input | DATA_W/8 | Byte-lane enables |
| req_wdata | input | DATA_W | Write data |
| req_secure | input | 1 | Requester is secure |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response cycle, one clock after the request |
| rsp_err | output | 1 | Request was denied |
| rsp_rdata | output | DATA_W | Read data, zero on denial or write |
| tgt_valid | output | 1 | Granted request forwarded to the port registers |
| tgt_write | output | 1 | Direction toward the target |
| tgt_addr | output | ADDR_W | Address toward the target |
| tgt_be | output | DATA_W/8 | Byte enables toward the target |
| tgt_wdata | output | DATA_W | Write data toward the target |
| tgt_rdata | input | DATA_W | Target read data, combinational on tgt_addr |

## Verification
A directed sweep sets all lanes to each of the eight codes. For each code it issues reads and writes from user nonsecure, user secure, privileged secure and privileged nonsecure requesters. This separates the grading of the table, and shows that a privileged nonsecure requester gets no extra rights. Directed patterns then give a single lane a restrictive code or the bypass bit, and issue single-lane and multi-lane enables. These show the little-endian lane mapping, the all-lanes rule and the bypass. After each denial, read-backs show that neither the target nor the protection word changed. A seeded random phase mixes policy rewrites from all classes with accesses that use random enables and random requester classes. Each response is compared with a bench model of the policy and of the port memory.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    localparam int LANE_W   = 8;
    localparam int CODE_W   = 3;
    localparam int BYPASS_B = 7;

    typedef enum logic [1:0] {
        CLS_USER_NS = 2'd0,
        CLS_USER_S  = 2'd1,
        CLS_PRIV_S  = 2'd2
    } req_class_e;

    // Returns {may_read, may_write} for one lane code and requester class.
    function automatic logic [1:0] lane_rights(input logic [CODE_W-1:0] code,
                                               input req_class_e cls);
        logic [1:0] r_uns, r_us, r_ps;
        case (code)
            3'd0:    begin r_uns = 2'b11; r_us = 2'b11; r_ps = 2'b11; end
            3'd1:    begin r_uns = 2'b10; r_us = 2'b11; r_ps = 2'b11; end
            3'd2:    begin r_uns = 2'b00; r_us = 2'b11; r_ps = 2'b11; end
            3'd3:    begin r_uns = 2'b10; r_us = 2'b10; r_ps = 2'b11; end
            3'd4:    begin r_uns = 2'b00; r_us = 2'b10; r_ps = 2'b11; end
            3'd5:    begin r_uns = 2'b00; r_us = 2'b00; r_ps = 2'b11; end
            3'd6:    begin r_uns = 2'b00; r_us = 2'b00; r_ps = 2'b10; end
            default: begin r_uns = 2'b00; r_us = 2'b00; r_ps = 2'b00; end
        endcase
        case (cls)
            CLS_USER_NS: lane_rights = r_uns;
            CLS_USER_S:  lane_rights = r_us;
            CLS_PRIV_S:  lane_rights = r_ps;
            default:     lane_rights = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/acc_class_map.sv
module acc_class_map
    import acc_guard_pkg::*;
(
    input  logic       secure,
    input  logic       priv,
    output req_class_e cls
);
    // A nonsecure requester is always checked as user nonsecure (R8).
    always_comb begin
        if (!secure)   cls = CLS_USER_NS;
        else if (priv) cls = CLS_PRIV_S;
        else           cls = CLS_USER_S;
    end
endmodule

// File: rtl/acc_lane_gate.sv
module acc_lane_gate
    import acc_guard_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              bypass,
    input  req_class_e        cls,
    input  logic              is_write,
    input  logic              touched,
    output logic              lane_ok
);
    logic [1:0] rights;
    logic       permitted;

    always_comb begin
        rights    = lane_rights(code, cls);
        permitted = is_write ? rights[0] : rights[1];
        lane_ok   = !touched || bypass || permitted;
    end
endmodule

// File: rtl/acc_byte_guard.sv
module acc_byte_guard
    import acc_guard_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int ATTR_ADDR = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W/8-1:0]      req_be,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_secure,
    input  logic                     req_priv,
    output logic                     rsp_valid,
    output logic                     rsp_err,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     tgt_valid,
    output logic                     tgt_write,
    output logic [ADDR_W-1:0]        tgt_addr,
    output logic [DATA_W/8-1:0]      tgt_be,
    output logic [DATA_W-1:0]        tgt_wdata,
    input  logic [DATA_W-1:0]        tgt_rdata
);
    localparam int LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] attr;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
    } state_t;

    state_t            st_d, st_q;
    req_class_e        cls;
    logic [LANES-1:0]  lane_ok;
    logic              all_ok;
    logic              attr_hit;
    logic              grant;
    logic [DATA_W-1:0] attr_q;

    acc_class_map u_cls (
        .secure (req_secure),
        .priv   (req_priv),
        .cls    (cls)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        acc_lane_gate u_gate (
            .code     (st_q.attr[i*LANE_W +: CODE_W]),
            .bypass   (st_q.attr[i*LANE_W + BYPASS_B]),
            .cls      (cls),
            .is_write (req_write),
            .touched  (req_be[i]),
            .lane_ok  (lane_ok[i])
        );
    end

    assign all_ok   = &lane_ok;
    assign attr_hit = (req_addr == ADDR_W'(ATTR_ADDR));
    assign grant    = attr_hit ? (!req_write || (cls == CLS_PRIV_S)) : all_ok;

    assign tgt_valid = req_valid && !attr_hit && all_ok;
    assign tgt_write = req_write;
    assign tgt_addr  = req_addr;
    assign tgt_be    = req_be;
    assign tgt_wdata = req_wdata;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = req_valid && !grant;
        st_d.rsp_rdata = '0;
        if (req_valid && !req_write && grant)
            st_d.rsp_rdata = attr_hit ? st_q.attr : tgt_rdata;
        if (req_valid && req_write && attr_hit && grant) begin
            for (int i = 0; i < LANES; i++) begin
                if (req_be[i])
                    st_d.attr[i*LANE_W +: LANE_W] = req_wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rsp_rdata;
    assign attr_q    = st_q.attr;
endmodule

// File: rtl/acc_byte_guard_chk.sv
module acc_byte_guard_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int ATTR_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_secure,
    input logic              req_priv,
    input logic              tgt_valid,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [DATA_W-1:0] attr_q
);
    AST_TGT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> req_valid); // R6
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_ERR_IN_RSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R6
    AST_FORWARDED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> !rsp_err); // R5
    AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !$past(req_write)) |-> (rsp_rdata == '0)); // R7
    AST_ATTR_PS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(attr_q) |-> $past(req_valid && req_write && req_secure && req_priv
                                   && req_addr == ADDR_W'(ATTR_ADDR))); // R9
endmodule

bind acc_byte_guard acc_byte_guard_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ATTR_ADDR(ATTR_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_secure(req_secure), .req_priv(req_priv),
    .tgt_valid(tgt_valid), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .attr_q(attr_q)
);

// File: tb/acc_byte_guard_tb_top.sv
module acc_byte_guard_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0, req_secure = 0, req_priv = 0;
    logic [3:0]  req_addr = 0, req_be = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid, rsp_err, tgt_valid, tgt_write;
    logic [31:0] rsp_rdata, tgt_wdata, tgt_rdata;
    logic [3:0]  tgt_addr, tgt_be;

    logic [31:0] tmem [16];
    logic [31:0] exp_mem [16];
    logic [31:0] exp_attr;
    int checks = 0, errs = 0;

    always #2 clk = ~clk;

    acc_byte_guard dut_i (.*);

    assign tgt_rdata = tmem[tgt_addr];
    always @(posedge clk)
        if (tgt_valid && tgt_write)
            for (int i = 0; i < 4; i++)
                if (tgt_be[i]) tmem[tgt_addr][i*8 +: 8] <= tgt_wdata[i*8 +: 8];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {read,write} per R2 table; class 0 UNS, 1 US, 2 PS.
    function automatic logic [1:0] rights(input logic [2:0] c, input int cls);
        logic [1:0] t [3];
        case (c)
            0: t = '{2'b11, 2'b11, 2'b11};
            1: t = '{2'b10, 2'b11, 2'b11};
            2: t = '{2'b00, 2'b11, 2'b11};
            3: t = '{2'b10, 2'b10, 2'b11};
            4: t = '{2'b00, 2'b10, 2'b11};
            5: t = '{2'b00, 2'b00, 2'b11};
            6: t = '{2'b00, 2'b00, 2'b10};
            default: t = '{2'b00, 2'b00, 2'b00};
        endcase
        return t[cls];
    endfunction

    function automatic logic exp_grant(input logic [3:0] a, input logic [3:0] be,
                                       input logic sec, input logic priv, input logic wr);
        int cls = !sec ? 0 : (priv ? 2 : 1); // R8
        logic ok = 1;
        if (a == 0) return !wr || (sec && priv); // R9, R11
        for (int i = 0; i < 4; i++) begin
            logic [7:0] lb = exp_attr[i*8 +: 8];
            logic [1:0] r = rights(lb[2:0], cls);
            if (be[i] && !lb[7] && !(wr ? r[0] : r[1])) ok = 0;
        end
        return ok;
    endfunction

    task automatic access(input logic [3:0] a, input logic [3:0] be, input logic [31:0] wd,
                          input logic sec, input logic priv, input logic wr, input string tag);
        logic g;
        logic [31:0] ed;
        @(negedge clk);
        check({tag, " R10 idle"}, {31'd0, rsp_valid}, 32'd0);
        req_valid = 1; req_addr = a; req_be = be; req_wdata = wd;
        req_secure = sec; req_priv = priv; req_write = wr;
        g  = exp_grant(a, be, sec, priv, wr);
        ed = (g && !wr) ? ((a == 0) ? exp_attr : exp_mem[a]) : 32'd0;
        #1;
        check({tag, " R6 tgt_valid"}, {31'd0, tgt_valid}, {31'd0, g && (a != 0)});
        @(negedge clk);
        req_valid = 0;
        check({tag, " R10 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " err"}, {31'd0, rsp_err}, {31'd0, !g});
        if (!wr) check({tag, " rdata"}, rsp_rdata, ed);
        if (g && wr)
            for (int i = 0; i < 4; i++)
                if (be[i]) begin
                    if (a == 0) exp_attr[i*8 +: 8] = wd[i*8 +: 8];
                    else        exp_mem[a][i*8 +: 8] = wd[i*8 +: 8];
                end
    endtask

    task automatic set_attr(input logic [31:0] v);
        access(0, 4'hF, v, 1, 1, 1, "R9 ps_set");
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) begin tmem[i] = 32'h1000_0000 * i + i; exp_mem[i] = tmem[i]; end
        exp_attr = 0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
        check("R1 tgt_valid", {31'd0, tgt_valid}, 0);
        rst_n = 1;
        check("R1 rsp_err", {31'd0, rsp_err}, 0);
        access(0, 4'hF, 0, 0, 0, 0, "R1 R11 attr_reset");
        access(5, 4'hF, 0, 0, 0, 0, "R1 uns_read");

        // R2 / R8: sweep every code over every class.
        for (int c = 0; c < 8; c++) begin
            set_attr({4{5'd0, 3'(c)}});
            for (int k = 0; k < 4; k++) begin
                logic s = (k != 0 && k != 3);
                logic p = (k >= 2);
                access(3, 4'hF, 32'hA500_0000 + c * 16 + k, s, p, 1, "R2 R8 sweep_wr");
                access(3, 4'hF, 0, s, p, 0, "R2 R8 sweep_rd");
            end
            access(0, 4'hF, 0, 0, 0, 0, "R11 attr_read_any");
        end

        // R3 lane mapping: only lane 2 denies.
        set_attr(32'h0007_0000);
        access(4, 4'b0001, 32'h11, 0, 0, 1, "R3 lane0_ok");
        access(4, 4'b0100, 32'h00220000, 0, 0, 1, "R3 lane2_denied");
        access(4, 4'b1011, 32'h33334433, 0, 0, 1, "R3 R5 skip_lane2");
        access(4, 4'b0110, 32'hFFFFFFFF, 1, 1, 1, "R5 R6 multi_denied");
        access(4, 4'b0100, 0, 1, 1, 0, "R7 denied_read");
        // R4 bypass on lane 2
        set_attr(32'h0087_0000);
        access(4, 4'b0110, 32'h00BEEF00, 0, 0, 1, "R4 bypass_wr");
        access(4, 4'b1111, 0, 0, 0, 0, "R4 bypass_rd");

        // R9 attribute writes from non-PS classes are refused.
        access(0, 4'hF, 32'h0505_0505, 1, 0, 1, "R9 us_write");
        access(0, 4'hF, 32'h0505_0505, 0, 1, 1, "R9 pns_write");
        access(0, 4'hF, 0, 0, 0, 0, "R9 unchanged");
        access(0, 4'b0010, 32'hFFFF_05FF, 1, 1, 1, "R9 ps_lane1");
        access(0, 4'hF, 0, 1, 0, 0, "R9 lane1_only");

        // Random mix.
        for (int n = 0; n < 600; n++) begin
            logic [3:0] a  = 4'($urandom_range(0, 15));
            logic [3:0] be = 4'($urandom_range(1, 15));
            logic [31:0] wd = $urandom;
            logic s = 1'($urandom), p = 1'($urandom), w = 1'($urandom);
            if (($urandom % 6) == 0) begin
                a = 0; w = 1;
                for (int i = 0; i < 4; i++)
                    wd[i*8 +: 8] = {(($urandom % 5) == 0), 4'd0, 3'($urandom)};
            end
            access(a, be, wd, s, p, w, "R2 R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule